// File: doc/BRIEF.md
# Multiplexed-Bus Host Register Port

This block is the host-facing access port of a display-style peripheral that sits on a two-phase multiplexed 8-bit address/data bus. During the address phase, the host drives an address byte on the shared AD lines and pulls the address strobe low. The block captures that byte and the chip-select level into a 9-bit temporary address. During the data phase, the host drives the data strobe low. The block then either takes a byte from AD into one of eight direct registers, or returns a byte on its AD output with the output-enable raised.

The captured address has three fields: a 3-bit register index, an execution-request bit, and a 4-bit self-select nibble. The device answers only when the nibble matches its configured value and the captured chip-select is low. When an answered access carries the execution-request bit, the block sends a single-clock execute strobe to a downstream command engine once the data phase ends. Index 0 behaves differently by direction: a write stores a command byte, and a read returns a status byte assembled from engine inputs. Indices 4/5 hold the auxiliary pointer bytes and 6/7 the main pointer bytes; indices 1 to 3 hold parameter and data bytes. The strobes are asynchronous and pass through a two-flop synchroniser before their edges are detected.

Top module: `mux_bus_regs`

## Requirements
- R1: After reset, all eight register bytes on `regs_o` are 0, `ad_oe` is 0 and `exec_o` is 0.
- R2: On a falling edge of `as_n`, the block captures `ad_in[7:0]` and `cs_n` into the temporary address. Bits [2:0] of that address select the register, bit 3 is the execution request and bits [7:4] are the select nibble.
- R3: The device is selected only when the captured nibble equals `SEL_NIB` (default 4'b0010) and the captured chip-select is 0.
- R4: In a selected write data phase (`rw`=0), the byte on `ad_in` is stored into register index 1 to 7. The new value appears on `regs_o[8*i +: 8]` three clocks after `ds_n` falls.
- R5: `ad_oe` is 1 only during a selected read (`rw`=1) while the synchronised data strobe is low. It rises two clocks after `ds_n` falls and drops two clocks after `ds_n` rises. While it is 1, `ad_out` carries register index 1 to 7.
- R6: A read of index 0 returns the status byte and never the stored command. The layout is bit7 busy, bit6 alarm, bit5 main-X-at-39, bit4 aux-X-at-39, bit2 vsync, and bits 3, 1 and 0 read as 0.
- R7: A selected write to index 0 stores the command byte in `regs_o[7:0]`. It is ignored while `st_busy` is 1.
- R8: When the device is not selected (wrong nibble or chip-select high), no register changes, `ad_oe` stays 0 and no execute strobe is produced.
- R9: A selected read or write with the execution-request bit set raises `exec_o` for exactly one clock. `exec_o` rises three clocks after `ds_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, falling edge captures the address, asynchronous |
| ds_n | input | 1 | Data strobe, low during the data phase, asynchronous |
| rw | input | 1 | Direction of the data phase: 1 read, 0 write |
| cs_n | input | 1 | Chip select, active low, captured with the address |
| ad_in | input | 8 | Shared AD lines as seen by the block |
| ad_out | output | 8 | Read data toward the AD lines |
| ad_oe | output | 1 | Output enable for the AD drivers |
| st_busy | input | 1 | Command engine busy |
| st_alarm | input | 1 | Alarm flag |
| st_main_x39 | input | 1 | Main pointer column at 39 |
| st_aux_x39 | input | 1 | Auxiliary pointer column at 39 |
| st_vsync | input | 1 | Vertical sync status |
| exec_o | output | 1 | One-clock execute strobe to the command engine |
| regs_o | output | 64 | Register bytes, index i at bits [8*i+7:8*i] |

## Verification
Each strobe edge passes through two synchroniser flops and an edge detector. The address is therefore captured, and a write lands in a register, on the third rising clock after the strobe changes. The read enable follows the data strobe after two clocks, and the execute strobe is high during the fourth clock after the data strobe rises. The bench's reference model changes its expected values at exactly those rising edges, counted from the moment the task drives the strobe. It compares registers, enable, read data and execute strobe on every falling clock edge, so a value that arrives one cycle early or late is reported.

// File: rtl/mux_bus_regs.sv
module mux_bus_regs #(
  parameter logic [3:0] SEL_NIB = 4'b0010,
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic        rw,
  input  logic        cs_n,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic        st_busy,
  input  logic        st_alarm,
  input  logic        st_main_x39,
  input  logic        st_aux_x39,
  input  logic        st_vsync,
  output logic        exec_o,
  output logic [63:0] regs_o
);
  localparam int IW = $clog2(NREG);

  logic [2:0] as_sy, ds_sy;
  logic [8:0] addr_q;
  logic [7:0] rf [NREG];
  logic       exec_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_sy <= 3'b111;
      ds_sy <= 3'b111;
    end else begin
      as_sy <= {as_sy[1:0], as_n};
      ds_sy <= {ds_sy[1:0], ds_n};
    end

  wire as_fall = as_sy[2] & ~as_sy[1];
  wire ds_fall = ds_sy[2] & ~ds_sy[1];
  wire ds_rise = ~ds_sy[2] & ds_sy[1];
  wire ds_act  = ~ds_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_q <= 9'h100;
    else if (as_fall) addr_q <= {cs_n, ad_in};

  wire [IW-1:0] idx = addr_q[IW-1:0];
  wire          xqr = addr_q[3];
  wire          sel = ~addr_q[8] & (addr_q[7:4] == SEL_NIB);
  wire          wr_ok = ds_fall & sel & ~rw & ~((idx == '0) & st_busy);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_ok) begin
      rf[idx] <= ad_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) exec_q <= 1'b0;
    else        exec_q <= ds_rise & sel & xqr;

  wire [7:0] status = {st_busy, st_alarm, st_main_x39, st_aux_x39, 1'b0, st_vsync, 2'b00};

  assign ad_oe  = sel & rw & ds_act;
  assign ad_out = (idx == '0) ? status : rf[idx];
  assign exec_o = exec_q;

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    assign regs_o[8*g +: 8] = rf[g];
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> !exec_o);

  a_r9_exec_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |-> sel);

  a_r8_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(regs_o));

  a_r7_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o[7:0]) |-> !$past(st_busy));

  a_r5_oe_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(regs_o));
endmodule

// File: tb/sim_mux_bus_regs.sv
`timescale 1ns/1ps
module sim_mux_bus_regs;
  logic clk = 0, rst_n = 0;
  logic as_n = 1, ds_n = 1, rw = 1, cs_n = 1;
  logic [7:0] ad_in = 0;
  logic busy = 0, alarm = 0, mx = 0, ax = 0, vs = 0;
  logic [7:0] ad_out;
  logic ad_oe, exec_o;
  logic [63:0] regs_o;

  mux_bus_regs u0 (.clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw(rw), .cs_n(cs_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .st_busy(busy), .st_alarm(alarm),
    .st_main_x39(mx), .st_aux_x39(ax), .st_vsync(vs), .exec_o(exec_o), .regs_o(regs_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, exec_seen = 0, exec_want = 0;
  string cur = "R1";
  logic [7:0] m_reg [8];
  logic m_oe = 0, m_exec = 0, m_sel = 0, m_xqr = 0, active = 0;
  logic [2:0] m_idx = 0;

  function automatic logic [63:0] packed_exp();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = m_reg[i];
    return v;
  endfunction

  function automatic logic [7:0] rd_exp();
    if (m_idx == 0) return {busy, alarm, mx, ax, 1'b0, vs, 2'b00};
    return m_reg[m_idx];
  endfunction

  always @(negedge clk) if (active) begin
    checks++;
    if (regs_o !== packed_exp()) begin
      errors++; $display("FAIL %s regs actual=%h expected=%h", cur, regs_o, packed_exp());
    end
    checks++;
    if (ad_oe !== m_oe) begin
      errors++; $display("FAIL %s/R5 ad_oe actual=%b expected=%b", cur, ad_oe, m_oe);
    end
    checks++;
    if (exec_o !== m_exec) begin
      errors++; $display("FAIL %s/R9 exec actual=%b expected=%b", cur, exec_o, m_exec);
    end
    if (m_oe) begin
      checks++;
      if (ad_out !== rd_exp()) begin
        errors++; $display("FAIL %s read data actual=%h expected=%h", cur, ad_out, rd_exp());
      end
    end
    if (exec_o === 1'b1) exec_seen++;
  end

  task automatic access(input logic rd, input logic csn, input logic [7:0] addr, input logic [7:0] wd);
    @(negedge clk); as_n = 0; cs_n = csn; ad_in = addr; rw = rd;
    repeat (3) @(posedge clk);
    m_sel = !csn && addr[7:4] == 4'b0010; m_xqr = addr[3]; m_idx = addr[2:0];
    @(negedge clk); as_n = 1;
    repeat (2) @(negedge clk);
    @(negedge clk); ad_in = wd; ds_n = 0;
    repeat (2) @(posedge clk);
    m_oe = m_sel && rd;
    @(posedge clk);
    if (m_sel && !rd && !(m_idx == 0 && busy)) m_reg[m_idx] = wd;
    repeat (3) @(negedge clk);
    ds_n = 1;
    repeat (2) @(posedge clk);
    m_oe = 0;
    @(posedge clk);
    m_exec = m_sel && m_xqr;
    if (m_exec) exec_want++;
    @(posedge clk);
    m_exec = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    active = 1;
    cur = "R1";
    repeat (3) @(negedge clk);

    cur = "R4";
    for (int i = 1; i < 8; i++) access(0, 0, {4'b0010, 1'b0, 3'(i)}, 8'(8'h11 * i + 3));
    cur = "R5";
    for (int i = 1; i < 8; i++) access(1, 0, {4'b0010, 1'b0, 3'(i)}, 8'h00);
    cur = "R6";
    {busy, alarm, mx, ax, vs} = 5'b10101; access(1, 0, 8'h20, 8'h00);
    {busy, alarm, mx, ax, vs} = 5'b01010; access(1, 0, 8'h20, 8'h00);
    {busy, alarm, mx, ax, vs} = 5'b00000;
    cur = "R7";
    access(0, 0, 8'h20, 8'h5A);
    busy = 1; access(0, 0, 8'h20, 8'hC3); busy = 0;
    cur = "R6";
    access(1, 0, 8'h20, 8'h00);
    cur = "R8";
    access(0, 1, 8'h21, 8'hEE);
    access(0, 0, 8'h32, 8'hEE);
    access(0, 0, 8'h2D, 8'hEE);
    access(1, 1, 8'h25, 8'h00);
    access(0, 1, 8'h2C, 8'h77);
    cur = "R2";
    access(0, 0, 8'h26, 8'h9C);
    access(1, 0, 8'h26, 8'h00);
    cur = "R3";
    access(0, 0, 8'hA3, 8'h44);
    access(0, 0, 8'h23, 8'h45);
    cur = "R9";
    access(0, 0, 8'h2B, 8'h61);
    access(1, 0, 8'h2F, 8'h00);
    busy = 1; access(0, 0, 8'h28, 8'h13); busy = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (exec_seen != exec_want) begin
      errors++; $display("FAIL R9 exec pulse count actual=%0d expected=%0d", exec_seen, exec_want);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule